// File: doc/BRIEF.md
# SPI Master Controller with Register Bus

This block is a single-lane SPI master that a processor drives through a small 32-bit register port. Software writes bytes into an eight-entry transmit queue. Whenever the controller is enabled and that queue holds data, a serial engine shifts one byte out on MOSI and shifts one byte in from MISO. Each received byte goes into an eight-entry receive queue, where software reads it back through a read port.

The serial clock period is set by a divider register. Clock polarity is a separate control bit. The edge that launches data and the edge that captures data are each chosen by their own bit, and each names a physical SCLK edge (rising or falling) rather than a phase. The chip select line is driven only by software, and its active level can be programmed.

Top module: `spim_ctrl`

## Requirements
- R1: Register offsets: control 0x00, divider 0x04, select 0x08, flush 0x10, status 0x14, transmit port 0x20, receive port 0x30.
  - Control bit 0 is enable, bit 1 captures on the falling edge, bit 2 launches on the falling edge, bit 3 sets SCLK idle high, and bit 13 selects LSB first. These bits read back as written.
  - Control bits 12:8 always read 8, and bit 18 and every other control bit read 0.
  - The divider keeps bits 7:0 of a write. The select register reads back bit 0 (assert) and bit 2 (active high).
- R2: After reset, status reads 0x00010100, the divider reads 3, SCLK is low and the select output is high.
- R3: The transmit queue holds 8 words, and a write to the transmit port while it is full is dropped. Status bits 31:28 give the transmit count, bit 17 is transmit full and bit 16 is transmit empty.
- R4: Each received word enters the receive queue. A word received while the queue holds 8 is discarded. Status bits 27:24 give the receive count, bit 9 is receive full and bit 8 is receive empty.
  - Reading port 0x30 returns the oldest word in bits 7:0 and removes it.
  - A read while the queue is empty returns 0 and removes nothing.
- R5: Writing 1 to flush-register bit 0 empties the receive queue, and writing 1 to bit 1 empties the transmit queue. The flush register always reads 0.
- R6: With control bit 13 clear, bits go out and are assembled MSB first. With it set, they are LSB first.
- R7: With the polarity bit clear, SCLK idles low and the rising edge opens each bit period; with it set, SCLK idles high and the falling edge opens each bit period.
  - Data changes on the edge chosen by bit 2 and is captured on the edge chosen by bit 1. These two edges are expected to differ.
- R8: With divider value N, each bit period lasts N+1 bus clocks when N is 1 or more. A value of 0 acts as 1. Consecutive words from a non-empty queue follow with no gap.
- R9: Status bit 0 (busy) is 1 while a word is in flight or the transmit queue is non-empty. It drops only after the last capture edge, once the queue is empty.
- R10: A divider or control change written during a word takes effect from the next word only.
- R11: The select output equals the active level (select bit 2) while select bit 0 is 1, and its inverse otherwise.
- R12: While enable is 0, no transfer starts: SCLK stays idle and queued words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and engine clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; pops the receive queue at 0x30 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csel | output | 1 | Software chip select |

## Verification
The main symptom of a broken engine state is a wrong bit on MOSI, or a wrong byte in the receive queue, within the same word. The bench models the slave from the edges it sees on SCLK, and compares every launched and captured byte across all four polarity and edge pairings and both bit orders.

A wrong bit counter or divider latch shows up as a bit period that is too long or too short, within one bit time. Queue-pointer faults appear in the status counts, and in read data after an overflow, an empty read or a flush.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned WORD_W     = 8;
    localparam int unsigned DIV_W      = 8;
    localparam int unsigned FIFO_DEPTH = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIV   = 8'h04;
    localparam logic [ADDR_W-1:0] A_SEL   = 8'h08;
    localparam logic [ADDR_W-1:0] A_FLUSH = 8'h10;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] A_TXD   = 8'h20;
    localparam logic [ADDR_W-1:0] A_RXD   = 8'h30;

    localparam int unsigned C_EN     = 0;
    localparam int unsigned C_SMPF   = 1;
    localparam int unsigned C_DRVF   = 2;
    localparam int unsigned C_CPOL   = 3;
    localparam int unsigned C_WID_LO = 8;
    localparam int unsigned C_LSB    = 13;

    // per-word serial mode, latched by the engine at each word start
    typedef struct packed {
        logic lsb;
        logic cpol;
        logic drv_fall;
        logic smp_fall;
        logic en;
    } mode_t;

    function automatic mode_t unpack_ctrl(input logic [DATA_W-1:0] w);
        mode_t m;
        m.en       = w[C_EN];
        m.smp_fall = w[C_SMPF];
        m.drv_fall = w[C_DRVF];
        m.cpol     = w[C_CPOL];
        m.lsb      = w[C_LSB];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input mode_t m);
        logic [DATA_W-1:0] r;
        r               = '0;
        r[C_EN]         = m.en;
        r[C_SMPF]       = m.smp_fall;
        r[C_DRVF]       = m.drv_fall;
        r[C_CPOL]       = m.cpol;
        r[C_LSB]        = m.lsb;
        r[C_WID_LO+:5]  = 5'(WORD_W);
        return r;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
// Synchronous queue; DEPTH must be a power of two so pointers wrap freely.
module spim_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/spim_engine.sv
// Serial engine: one word per load, mode and divider frozen for the word.
module spim_engine
    import spim_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned DW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  mode_t         mode,
    input  logic [DW-1:0] div,
    input  logic [W-1:0]  tx_word,
    output logic          take,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          rx_push,
    output logic [W-1:0]  rx_word,
    output logic          active,
    output logic [DW-1:0] div_cur
);
    localparam int unsigned BW = $clog2(W);

    mode_t          m_q;
    logic [DW-1:0]  cnt;
    logic [BW-1:0]  bitn;
    logic [W-1:0]   tx_sr, rx_sr, rx_nx;
    logic           sclk_q;
    logic [DW-1:0]  divc, half;
    logic           lead_ev, trail_ev, drv_lead, smp_lead, drv_ev, smp_ev, last;
    logic           unused_en;

    assign unused_en = mode.en;

    always_comb begin
        divc     = (div_cur == '0) ? DW'(1) : div_cur;
        half     = divc >> 1;
        lead_ev  = active && (cnt == half);
        trail_ev = active && (cnt == divc);
        // leading edge is falling exactly when the idle level is high
        drv_lead = (m_q.drv_fall == m_q.cpol);
        smp_lead = (m_q.smp_fall == m_q.cpol);
        drv_ev   = drv_lead ? (lead_ev && (bitn != '0)) : trail_ev;
        smp_ev   = smp_lead ? lead_ev : trail_ev;
        last     = trail_ev && (bitn == BW'(W - 1));
        rx_nx    = m_q.lsb ? {miso, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso};
        take     = go && (!active || last);
        rx_push  = last;
        rx_word  = smp_ev ? rx_nx : rx_sr;
        sclk     = active ? sclk_q : mode.cpol;
        mosi     = active ? (m_q.lsb ? tx_sr[0] : tx_sr[W-1]) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cnt     <= '0;
            bitn    <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            m_q     <= '0;
            div_cur <= '0;
            sclk_q  <= 1'b0;
        end else if (take) begin
            active  <= 1'b1;
            cnt     <= '0;
            bitn    <= '0;
            tx_sr   <= tx_word;
            rx_sr   <= '0;
            m_q     <= mode;
            div_cur <= div;
            sclk_q  <= mode.cpol;
        end else if (last) begin
            active  <= 1'b0;
            sclk_q  <= m_q.cpol;
        end else if (active) begin
            if (trail_ev) begin
                cnt    <= '0;
                bitn   <= bitn + 1'b1;
                sclk_q <= m_q.cpol;
            end else begin
                cnt <= cnt + 1'b1;
                if (lead_ev) sclk_q <= !m_q.cpol;
            end
            if (drv_ev) tx_sr <= m_q.lsb ? (tx_sr >> 1) : (tx_sr << 1);
            if (smp_ev) rx_sr <= rx_nx;
        end
    end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              csel
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    mode_t             mode_q;
    logic [DIV_W-1:0]  div_q, div_lat;
    logic              sel_on, sel_high;
    logic              wr_ctrl, wr_div, wr_sel, wr_flush, wr_tx, rd_rx;
    logic              tx_flush, rx_flush, rx_pop;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              take, rx_push, active, busy, go;
    logic [DATA_W-1:0] stat;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:14], bus_wdata[12:8]};

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_div   = bus_wr && (bus_addr == A_DIV);
    assign wr_sel   = bus_wr && (bus_addr == A_SEL);
    assign wr_flush = bus_wr && (bus_addr == A_FLUSH);
    assign wr_tx    = bus_wr && (bus_addr == A_TXD);
    assign rd_rx    = bus_rd && (bus_addr == A_RXD);
    assign rx_flush = wr_flush && bus_wdata[0];
    assign tx_flush = wr_flush && bus_wdata[1];
    assign rx_pop   = rd_rx && !rx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            div_q    <= DIV_W'(3);
            sel_on   <= 1'b0;
            sel_high <= 1'b0;
        end else begin
            if (wr_ctrl) mode_q <= unpack_ctrl(bus_wdata);
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            if (wr_sel) begin
                sel_on   <= bus_wdata[0];
                sel_high <= bus_wdata[2];
            end
        end
    end

    assign csel = ~(sel_on ^ sel_high);

    spim_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(wr_tx), .wdata(bus_wdata[WORD_W-1:0]),
        .pop(take), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign go = mode_q.en && !tx_empty;

    spim_engine #(.W(WORD_W), .DW(DIV_W)) u_eng (
        .clk(clk), .rst(rst), .go(go), .mode(mode_q), .div(div_q),
        .tx_word(tx_head), .take(take), .miso(miso),
        .sclk(sclk), .mosi(mosi), .rx_push(rx_push), .rx_word(rx_word),
        .active(active), .div_cur(div_lat)
    );

    assign busy = active || !tx_empty;

    always_comb begin
        stat        = '0;
        stat[31:28] = 4'(tx_cnt);
        stat[27:24] = 4'(rx_cnt);
        stat[17]    = tx_full;
        stat[16]    = tx_empty;
        stat[9]     = rx_full;
        stat[8]     = rx_empty;
        stat[0]     = busy;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = pack_ctrl(mode_q);
            A_DIV:   bus_rdata = DATA_W'(div_q);
            A_SEL:   bus_rdata = {29'b0, sel_high, 1'b0, sel_on};
            A_STAT:  bus_rdata = stat;
            A_RXD:   bus_rdata = rx_empty ? '0 : DATA_W'(rx_head);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          active,
    input logic          word_start,
    input logic          go_en,
    input logic          rx_push,
    input logic          rd_rx_empty,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [7:0]    div_lat
);
    p_tx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CW'(DEPTH));

    p_rx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CW'(DEPTH));

    p_rx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_rx_empty && !rx_push) |=> (rx_cnt == '0));

    p_div_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (active && !word_start) |=> $stable(div_lat));

    p_start_gated_r12: assert property (@(posedge clk) disable iff (rst)
        word_start |-> (go_en && tx_cnt != '0));

    p_busy_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt != '0) |-> busy);
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .active(active),
    .word_start(take), .go_en(mode_q.en), .rx_push(rx_push),
    .rd_rx_empty(rd_rx && rx_empty), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .div_lat(div_lat)
);

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
    localparam logic [7:0] A_CTRL = 8'h00, A_DIV = 8'h04, A_SEL = 8'h08,
                           A_FLUSH = 8'h10, A_STAT = 8'h14, A_TXD = 8'h20, A_RXD = 8'h30;

    logic        clk = 1'b0, rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        sclk, mosi, csel;
    logic        miso = 1'b0;

    spim_ctrl u_spim_ctrl (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_wdata(wdata), .bus_rdata(rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .csel(csel)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model state
    logic       m_lsb = 0, m_rxneg = 0, m_sclk_q = 0, m_mosi_q = 0;
    int         s_cnt = 0, mon_n = 0, nrise = 0;
    logic [7:0] acc = '0;
    logic [7:0] mon_w [0:31];
    logic [7:0] slv   [0:31];
    logic [7:0] tx_w  [0:31];
    int         rise_t [0:63];

    function automatic logic sbit(input logic [7:0] w, input int k, input logic lsb);
        return lsb ? w[k] : w[7-k];
    endfunction

    function automatic logic [31:0] stat_word(input int txc, input int rxc, input bit busy);
        logic [31:0] s;
        s = '0;
        s[31:28] = 4'(txc);
        s[27:24] = 4'(rxc);
        s[17] = (txc == 8);
        s[16] = (txc == 0);
        s[9]  = (rxc == 8);
        s[8]  = (rxc == 0);
        s[0]  = busy;
        return s;
    endfunction

    always @(negedge clk) begin
        if (!rst && sclk !== m_sclk_q) begin
            if (sclk === 1'b1) begin
                if (nrise < 64) rise_t[nrise] = cyc;
                nrise++;
            end
            if ((sclk === 1'b1) == !m_rxneg) begin
                acc[m_lsb ? (s_cnt % 8) : 7 - (s_cnt % 8)] = m_mosi_q;
                if (s_cnt % 8 == 7) begin
                    if (mon_n < 32) mon_w[mon_n] = acc;
                    mon_n++;
                end
                s_cnt++;
                if (s_cnt / 8 < 32) miso = sbit(slv[s_cnt / 8], s_cnt % 8, m_lsb);
            end
        end
        m_sclk_q = sclk;
        m_mosi_q = mosi;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, s);
            if (!s[0]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit smpf, input bit drvf,
                                              input bit cpol, input bit lsb);
        return {18'b0, lsb, 13'b0} | {28'b0, cpol, drvf, smpf, en};
    endfunction

    // program mode with enable off, let idle level settle, clear slave model
    task automatic set_mode(input bit smpf, input bit drvf, input bit cpol, input bit lsb,
                            input logic [7:0] dv);
        wr(A_CTRL, ctrl_word(0, smpf, drvf, cpol, lsb));
        wr(A_DIV, {24'b0, dv});
        m_rxneg = smpf;
        m_lsb   = lsb;
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        s_cnt = 0; mon_n = 0; nrise = 0; acc = '0;
        miso = sbit(slv[0], 0, lsb);
    endtask

    task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input logic [7:0] dv,
                        input int n);
        logic [31:0] r;
        bit smpf;
        smpf = cpol ^ cpha;
        set_mode(smpf, !smpf, cpol, lsb, dv);
        for (int i = 0; i < n; i++) wr(A_TXD, {24'b0, tx_w[i]});
        wr(A_CTRL, ctrl_word(1, smpf, !smpf, cpol, lsb));
        wait_idle();
        chk("R7 word count", mon_n, n);
        for (int i = 0; i < n; i++) chk("R6 R7 mosi word", {24'b0, mon_w[i]}, {24'b0, tx_w[i]});
        for (int i = 0; i < n; i++) begin
            rd(A_RXD, r);
            chk("R4 R6 miso word", r, {24'b0, slv[i]});
        end
        chk("R7 idle sclk level", {31'b0, sclk}, {31'b0, cpol});
        rd(A_STAT, r);
        chk("R9 idle status", r, stat_word(0, 0, 0));
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic [31:0] r;
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 32; i++) begin
            tx_w[i] = 8'($urandom);
            slv[i]  = 8'($urandom);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        rd(A_STAT, r);  chk("R2 status", r, 32'h0001_0100);
        rd(A_DIV, r);   chk("R2 divider", r, 32'd3);
        chk("R2 sclk", {31'b0, sclk}, 32'd0);
        chk("R2 select", {31'b0, csel}, 32'd1);

        // R1 readback
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, r); chk("R1 control", r, 32'h0000_280F);
        wr(A_CTRL, 32'h0);         rd(A_CTRL, r); chk("R1 control clear", r, 32'h0000_0800);
        wr(A_DIV, 32'h1FF);        rd(A_DIV, r);  chk("R1 divider", r, 32'hFF);
        wr(A_SEL, 32'hF);          rd(A_SEL, r);  chk("R1 select", r, 32'h5);

        // R11 select level
        chk("R11 on high", {31'b0, csel}, 32'd1);
        wr(A_SEL, 32'h4); chk("R11 off high", {31'b0, csel}, 32'd0);
        wr(A_SEL, 32'h1); chk("R11 on low", {31'b0, csel}, 32'd0);
        wr(A_SEL, 32'h0); chk("R11 off low", {31'b0, csel}, 32'd1);

        // R6 R7 all pairings, both orders; directed extremes first
        tx_w[0] = 8'h00; slv[0] = 8'hFF; tx_w[2] = 8'hA5; slv[2] = 8'h01;
        for (int m = 0; m < 8; m++) begin
            xfer(m[0], m[1], m[2], 8'($urandom % 5), 3);
            for (int i = 0; i < 3; i++) begin tx_w[i] = 8'($urandom); slv[i] = 8'($urandom); end
        end

        // R8 period with divider 5, back-to-back words
        set_mode(0, 1, 0, 0, 8'd5);
        wr(A_TXD, 32'h3C); wr(A_TXD, 32'hC3);
        wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
        wait_idle();
        chk("R8 rises", nrise, 16);
        for (int i = 1; i < 16; i++) chk("R8 period N=5", rise_t[i] - rise_t[i-1], 6);
        // R8 divider 0 acts as 1
        set_mode(0, 1, 0, 0, 8'd0);
        wr(A_TXD, 32'h96);
        wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
        wait_idle();
        for (int i = 1; i < 8; i++) chk("R8 period N=0", rise_t[i] - rise_t[i-1], 2);
        rd(A_RXD, r); rd(A_RXD, r); rd(A_RXD, r);

        // R10 divider change mid-word
        set_mode(0, 1, 0, 0, 8'd3);
        wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
        wait (nrise >= 2);
        wr(A_DIV, 32'd7);
        wait_idle();
        for (int i = 1; i < 8; i++)  chk("R10 old period", rise_t[i] - rise_t[i-1], 4);
        for (int i = 9; i < 16; i++) chk("R10 new period", rise_t[i] - rise_t[i-1], 8);
        rd(A_RXD, r); rd(A_RXD, r);

        // R12 disabled holds words; R9 busy while pending
        set_mode(0, 1, 0, 1, 8'd1);
        wr(A_TXD, {24'b0, tx_w[0]}); wr(A_TXD, {24'b0, tx_w[1]});
        repeat (40) @(negedge clk);
        chk("R12 no edges", nrise, 0);
        rd(A_STAT, r); chk("R12 R9 pending status", r, stat_word(2, 0, 1));
        wr(A_CTRL, ctrl_word(1, 0, 1, 0, 1));
        wait_idle();
        chk("R12 sent after enable", mon_n, 2);
        rd(A_STAT, r); chk("R4 two received", r, stat_word(0, 2, 0));
        // R5 receive flush
        wr(A_FLUSH, 32'h1);
        rd(A_STAT, r);  chk("R5 rx flushed", r, stat_word(0, 0, 0));
        rd(A_FLUSH, r); chk("R5 flush reads zero", r, 32'h0);

        // R5 transmit flush
        set_mode(0, 1, 0, 0, 8'd1);
        for (int i = 0; i < 3; i++) wr(A_TXD, 32'h55);
        rd(A_STAT, r); chk("R3 three queued", r, stat_word(3, 0, 1));
        wr(A_FLUSH, 32'h2);
        rd(A_STAT, r); chk("R5 tx flushed", r, stat_word(0, 0, 0));

        // R3 full queue drops ninth write
        set_mode(0, 1, 0, 0, 8'd1);
        for (int i = 0; i < 9; i++) wr(A_TXD, {24'b0, tx_w[i]});
        rd(A_STAT, r); chk("R3 full status", r, stat_word(8, 0, 1));
        wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
        wait_idle();
        chk("R3 eight sent", mon_n, 8);
        for (int i = 0; i < 8; i++) chk("R3 sent word", {24'b0, mon_w[i]}, {24'b0, tx_w[i]});
        rd(A_STAT, r); chk("R4 rx full", r, stat_word(0, 8, 0));

        // R4 ninth received word discarded
        wr(A_TXD, {24'b0, tx_w[8]});
        wait_idle();
        chk("R4 ninth sent", mon_n, 9);
        rd(A_STAT, r); chk("R4 still full", r, stat_word(0, 8, 0));
        for (int i = 0; i < 8; i++) begin
            rd(A_RXD, r); chk("R4 kept word", r, {24'b0, slv[i]});
        end
        rd(A_RXD, r);  chk("R4 empty read", r, 32'h0);
        rd(A_STAT, r); chk("R4 empty status", r, stat_word(0, 0, 0));
        rd(A_RXD, r);  chk("R4 empty read again", r, 32'h0);
        rd(A_STAT, r); chk("R4 pointer held", r, stat_word(0, 0, 0));

        report();
    end
endmodule